// File: doc/BRIEF.md
# Row-Based Functional Unit Allocator

This block places a stream of decoded instructions onto a grid of identical functional units. The grid is `ROWS` rows by `COLS` columns. Row 0 is the bottom row and column 0 is the leftmost column. Results move only upward through the grid, and units in the same row never pass data to each other. Each instruction names two source registers and one destination register. The allocator remembers which row produced each register in the configuration that is currently open. A dependent instruction is placed above its producers. Independent instructions share the lowest row that has room.

The block keeps a busy/free map of all units. A defect mask is loaded before operation, and every unit it marks stays busy permanently, so the placement logic never has to treat defects as a special case. When no legal free unit remains, the open configuration closes and a new one opens with the current instruction as its first entry. Every result carries the program counter of the instruction that opened its configuration.

Instructions enter through a valid/ready handshake. Each placement is returned through a second valid/ready handshake one cycle after the instruction is accepted.

Top module: `rowalloc_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The first instruction accepted after reset opens a configuration and reports `out_new_cfg` = 1.
- R2: An instruction whose sources have no producer in the open configuration has a minimum row of 0. Several such instructions fill row 0 from left to right.
- R3: A source register written by an instruction already placed in the open configuration raises the minimum row to one above that producer's row. The highest such row over both sources decides. Register 0 never creates a dependency.
- R4: The chosen unit is the first free unit at or above the minimum row. The scan takes the lowest such row that has a free unit, and the lowest free column within that row. A granted unit is busy for the rest of its configuration. Unit index = row*COLS + column.
- R5: If the minimum row has no free unit, the instruction goes to the next higher row that has one. Instructions that depend on it land at least one row above that.
- R6: A 1 in bit row*COLS+column of the defect mask makes that unit busy in every configuration, including after each restart.
- R7: If no free unit exists at or above the minimum row (this includes a minimum row of `ROWS` or more), the configuration closes. The map is reset so that only defective units are busy, and the producer table is cleared. The instruction is then placed by the R4 scan from row 0 and reports `out_new_cfg` = 1.
- R8: `out_cfg_pc` equals the `in_pc` of the instruction that opened the configuration the result belongs to.
- R9: A result appears on the cycle after acceptance and is held stable while `out_ready` is 0. `in_ready` is 0 while an unconsumed result is pending and during a defect load.
- R10: If every unit is defective, an instruction reports `out_unplaceable` = 1 with `out_new_cfg` = 1. The next instruction also opens a new configuration.
- R11: A defect load replaces the mask, frees all non-defective units and closes the open configuration, so the next instruction reports `out_new_cfg` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defect_load | input | 1 | Capture `defect_mask` and restart the map |
| defect_mask | input | ROWS*COLS | 1 = unit defective, bit row*COLS+col |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted |
| in_pc | input | PC_W | Program counter of the instruction |
| in_src_a | input | log2(NREG) | First source register |
| in_src_b | input | log2(NREG) | Second source register |
| in_dst | input | log2(NREG) | Destination register |
| out_valid | output | 1 | Placement result present |
| out_ready | input | 1 | Consumer takes the result |
| out_row | output | log2(ROWS) | Granted row, 0 = bottom |
| out_col | output | log2(COLS) | Granted column, 0 = left |
| out_new_cfg | output | 1 | Instruction opened a new configuration |
| out_cfg_pc | output | PC_W | Tag of the configuration |
| out_unplaceable | output | 1 | No working unit exists at all |

## Verification
Closing a configuration and placing an instruction happen in the same cycle. The instruction that finds no legal unit must also be the first entry of the fresh map, and the producer table must be cleared while that instruction's own destination is recorded. This is provoked in two ways. One is a dependency chain that reaches the top row. The other is a defect pattern that leaves the lower rows full. The check is that the closing instruction lands at the lowest non-defective position with the new-configuration flag and its own tag. The check also confirms that the very next instruction depends only on that closing instruction's destination.

// File: rtl/rowalloc_pkg.sv
package rowalloc_pkg;

  // Bits needed to index n items, at least one.
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {
    PLACE_CUR   = 2'd0,
    PLACE_FRESH = 2'd1,
    PLACE_NONE  = 2'd2
  } place_kind_e;

endpackage

// File: rtl/rowalloc_deps.sv
// Producer table: records the row that last wrote each register in the
// open configuration and derives the lowest legal row for a new entry.
module rowalloc_deps #(
  parameter int NREG = 32,
  parameter int RA_W = 5,
  parameter int HW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic [RA_W-1:0] src_a,
  input  logic [RA_W-1:0] src_b,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_reg,
  input  logic [HW-1:0]   wr_row,
  output logic [HW-1:0]   min_row
);

  logic [HW-1:0]   row_mem [NREG];
  logic [NREG-1:0] seen;
  logic [HW-1:0]   lvl_a, lvl_b;

  // Row storage carries no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) row_mem[wr_reg] <= wr_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
    end else begin
      if (clear) seen <= '0;
      if (wr_en) seen[wr_reg] <= 1'b1;
    end
  end

  always_comb begin
    lvl_a = '0;
    lvl_b = '0;
    if (src_a != '0 && seen[src_a]) lvl_a = row_mem[src_a] + HW'(1);
    if (src_b != '0 && seen[src_b]) lvl_b = row_mem[src_b] + HW'(1);
    min_row = (lvl_a > lvl_b) ? lvl_a : lvl_b;
  end

endmodule

// File: rtl/rowalloc_finder.sv
// Bottom-left first-free search over a busy map, restricted to rows at or
// above a minimum row.
module rowalloc_finder #(
  parameter int ROWS = 5,
  parameter int COLS = 5,
  parameter int HW   = 3,
  parameter int RW   = 3,
  parameter int CW   = 3
) (
  input  logic [ROWS*COLS-1:0] busy,
  input  logic [HW-1:0]        min_row,
  output logic                 found,
  output logic [RW-1:0]        row,
  output logic [CW-1:0]        col
);

  logic [COLS-1:0] free_c [ROWS];
  logic [ROWS-1:0] row_ok;

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      assign free_c[r] = ~busy[r*COLS +: COLS];
      assign row_ok[r] = (|free_c[r]) && (r >= int'(min_row));
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    row   = '0;
    col   = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (row_ok[i]) begin
        found = 1'b1;
        row   = RW'(i);
      end
    end
    for (int j = COLS - 1; j >= 0; j--) begin
      if (free_c[row][j]) col = CW'(j);
    end
  end

endmodule

// File: rtl/rowalloc_map.sv
// Busy map plus defect copy; searches the live map and a fresh map.
module rowalloc_map #(
  parameter int ROWS = 5,
  parameter int COLS = 5,
  parameter int HW   = 3,
  parameter int RW   = 3,
  parameter int CW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [ROWS*COLS-1:0] load_mask,
  input  logic [HW-1:0]        min_row,
  input  logic                 commit,
  input  logic                 use_fresh,
  input  logic                 mark_en,
  input  logic [RW-1:0]        mark_row,
  input  logic [CW-1:0]        mark_col,
  output logic                 cur_found,
  output logic [RW-1:0]        cur_row,
  output logic [CW-1:0]        cur_col,
  output logic                 fresh_found,
  output logic [RW-1:0]        fresh_row,
  output logic [CW-1:0]        fresh_col
);

  localparam int NU = ROWS * COLS;

  logic [NU-1:0] busy_q, defect_q, mark_vec, base;

  always_comb begin
    mark_vec = '0;
    if (mark_en) mark_vec[int'(mark_row) * COLS + int'(mark_col)] = 1'b1;
    base = use_fresh ? defect_q : busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= '0;
      defect_q <= '0;
    end else if (load) begin
      busy_q   <= load_mask;
      defect_q <= load_mask;
    end else if (commit) begin
      busy_q <= base | mark_vec;
    end
  end

  rowalloc_finder #(.ROWS(ROWS), .COLS(COLS), .HW(HW), .RW(RW), .CW(CW)) u_cur (
    .busy(busy_q), .min_row(min_row),
    .found(cur_found), .row(cur_row), .col(cur_col)
  );

  rowalloc_finder #(.ROWS(ROWS), .COLS(COLS), .HW(HW), .RW(RW), .CW(CW)) u_fresh (
    .busy(defect_q), .min_row(HW'(0)),
    .found(fresh_found), .row(fresh_row), .col(fresh_col)
  );

endmodule

// File: rtl/rowalloc_top.sv
module rowalloc_top #(
  parameter int ROWS = 5,
  parameter int COLS = 5,
  parameter int NREG = 32,
  parameter int PC_W = 32
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       defect_load,
  input  logic [ROWS*COLS-1:0]                       defect_mask,
  input  logic                                       in_valid,
  output logic                                       in_ready,
  input  logic [PC_W-1:0]                            in_pc,
  input  logic [rowalloc_pkg::bits_for(NREG)-1:0]    in_src_a,
  input  logic [rowalloc_pkg::bits_for(NREG)-1:0]    in_src_b,
  input  logic [rowalloc_pkg::bits_for(NREG)-1:0]    in_dst,
  output logic                                       out_valid,
  input  logic                                       out_ready,
  output logic [rowalloc_pkg::bits_for(ROWS)-1:0]    out_row,
  output logic [rowalloc_pkg::bits_for(COLS)-1:0]    out_col,
  output logic                                       out_new_cfg,
  output logic [PC_W-1:0]                            out_cfg_pc,
  output logic                                       out_unplaceable
);
  import rowalloc_pkg::*;

  localparam int RA_W = bits_for(NREG);
  localparam int RW   = bits_for(ROWS);
  localparam int CW   = bits_for(COLS);
  localparam int HW   = bits_for(ROWS + 1);

  logic            accept, start_cfg, placed, cfg_open;
  logic [PC_W-1:0] cfg_pc;
  logic [HW-1:0]   min_row;
  logic            cur_found, fresh_found;
  logic [RW-1:0]   cur_row, fresh_row, sel_row;
  logic [CW-1:0]   cur_col, fresh_col, sel_col;
  place_kind_e     kind;

  assign in_ready  = (!out_valid || out_ready) && !defect_load;
  assign accept    = in_valid && in_ready;
  assign start_cfg = !cfg_open || !cur_found;

  always_comb begin
    if (!start_cfg)      kind = PLACE_CUR;
    else if (fresh_found) kind = PLACE_FRESH;
    else                  kind = PLACE_NONE;
    case (kind)
      PLACE_CUR:   begin sel_row = cur_row;   sel_col = cur_col;   end
      PLACE_FRESH: begin sel_row = fresh_row; sel_col = fresh_col; end
      default:     begin sel_row = '0;        sel_col = '0;        end
    endcase
    placed = (kind != PLACE_NONE);
  end

  rowalloc_deps #(.NREG(NREG), .RA_W(RA_W), .HW(HW)) u_deps (
    .clk(clk), .rst(rst),
    .clear((accept && start_cfg) || defect_load),
    .src_a(in_src_a), .src_b(in_src_b),
    .wr_en(accept && placed && (in_dst != '0)),
    .wr_reg(in_dst), .wr_row(HW'(sel_row)),
    .min_row(min_row)
  );

  rowalloc_map #(.ROWS(ROWS), .COLS(COLS), .HW(HW), .RW(RW), .CW(CW)) u_map (
    .clk(clk), .rst(rst),
    .load(defect_load), .load_mask(defect_mask),
    .min_row(min_row),
    .commit(accept), .use_fresh(start_cfg),
    .mark_en(placed), .mark_row(sel_row), .mark_col(sel_col),
    .cur_found(cur_found), .cur_row(cur_row), .cur_col(cur_col),
    .fresh_found(fresh_found), .fresh_row(fresh_row), .fresh_col(fresh_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_open <= 1'b0;
      cfg_pc   <= '0;
    end else if (defect_load) begin
      cfg_open <= 1'b0;
    end else if (accept) begin
      cfg_open <= placed;
      if (start_cfg) cfg_pc <= in_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_row         <= '0;
      out_col         <= '0;
      out_new_cfg     <= 1'b0;
      out_cfg_pc      <= '0;
      out_unplaceable <= 1'b0;
    end else if (accept) begin
      out_valid       <= 1'b1;
      out_row         <= sel_row;
      out_col         <= sel_col;
      out_new_cfg     <= start_cfg;
      out_cfg_pc      <= start_cfg ? in_pc : cfg_pc;
      out_unplaceable <= !placed;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rowalloc_chk.sv
module rowalloc_chk #(
  parameter int ROWS = 5,
  parameter int COLS = 5,
  parameter int NREG = 32,
  parameter int PC_W = 32
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic                                    defect_load,
  input logic [ROWS*COLS-1:0]                    defect_mask,
  input logic                                    in_valid,
  input logic                                    in_ready,
  input logic [PC_W-1:0]                         in_pc,
  input logic                                    out_valid,
  input logic                                    out_ready,
  input logic [rowalloc_pkg::bits_for(ROWS)-1:0] out_row,
  input logic [rowalloc_pkg::bits_for(COLS)-1:0] out_col,
  input logic                                    out_new_cfg,
  input logic [PC_W-1:0]                         out_cfg_pc,
  input logic                                    out_unplaceable
);
  localparam int NU = ROWS * COLS;

  logic [NU-1:0]   dq, used, hit;
  logic [PC_W-1:0] last_pc;
  logic            acc, take, in_range;
  int              idx;

  assign acc  = in_valid && in_ready;
  assign take = out_valid && out_ready;

  always_comb begin
    in_range = (int'(out_row) < ROWS) && (int'(out_col) < COLS);
    idx      = in_range ? int'(out_row) * COLS + int'(out_col) : 0;
    hit      = NU'(1) << idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq      <= '0;
      used    <= '0;
      last_pc <= '0;
    end else begin
      if (acc) last_pc <= in_pc;
      if (defect_load) begin
        dq   <= defect_mask;
        used <= '0;
      end else if (take) begin
        if (out_unplaceable) used <= '0;
        else used <= (out_new_cfg ? '0 : used) | hit;
      end
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_col)
      && $stable(out_cfg_pc) && $stable(out_new_cfg));
  assert_range_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_unplaceable |-> in_range);
  assert_no_defect_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_unplaceable |-> !dq[idx]);
  assert_no_reuse_R4: assert property (@(posedge clk) disable iff (rst)
    take && !out_new_cfg && !out_unplaceable |-> !used[idx]);
  assert_tag_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_new_cfg |-> out_cfg_pc == last_pc);
  assert_unplaceable_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_unplaceable |-> out_new_cfg && (&dq));

endmodule

bind rowalloc_top rowalloc_chk #(.ROWS(ROWS), .COLS(COLS), .NREG(NREG), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .defect_load(defect_load), .defect_mask(defect_mask),
  .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
  .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_col(out_col),
  .out_new_cfg(out_new_cfg), .out_cfg_pc(out_cfg_pc), .out_unplaceable(out_unplaceable)
);

// File: tb/sim_rowalloc_top.sv
module sim_rowalloc_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        defect_load = 1'b0;
  logic [24:0] defect_mask = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [4:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_row, out_col;
  logic        out_new_cfg;
  logic [31:0] out_cfg_pc;
  logic        out_unplaceable;

  int tests = 0;
  int fails = 0;
  logic [31:0] tag = '0;

  always #10 clk = ~clk;

  rowalloc_top u0 (
    .clk(clk), .rst(rst), .defect_load(defect_load), .defect_mask(defect_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_col(out_col),
    .out_new_cfg(out_new_cfg), .out_cfg_pc(out_cfg_pc), .out_unplaceable(out_unplaceable)
  );

  // {pc16, src_a5, src_b5, dst5, row3, col3, new1, unplaceable1}
  localparam logic [38:0] VEC [15] = '{
    {16'd100, 5'd1,  5'd2,  5'd3,  3'd0, 3'd0, 1'b1, 1'b0}, // R1 opens cfg, R2
    {16'd104, 5'd1,  5'd2,  5'd4,  3'd0, 3'd1, 1'b0, 1'b0}, // R2 same row
    {16'd108, 5'd3,  5'd4,  5'd5,  3'd1, 3'd0, 1'b0, 1'b0}, // R3
    {16'd112, 5'd5,  5'd0,  5'd6,  3'd2, 3'd0, 1'b0, 1'b0}, // R3
    {16'd116, 5'd0,  5'd0,  5'd7,  3'd0, 3'd2, 1'b0, 1'b0}, // R3 reg 0
    {16'd120, 5'd6,  5'd7,  5'd8,  3'd3, 3'd0, 1'b0, 1'b0}, // R3 highest producer
    {16'd124, 5'd8,  5'd8,  5'd9,  3'd4, 3'd0, 1'b0, 1'b0}, // R3
    {16'd128, 5'd9,  5'd1,  5'd10, 3'd0, 3'd0, 1'b1, 1'b0}, // R7 above top row
    {16'd132, 5'd9,  5'd10, 5'd11, 3'd1, 3'd0, 1'b0, 1'b0}, // R7 table cleared
    {16'd136, 5'd0,  5'd0,  5'd0,  3'd0, 3'd1, 1'b0, 1'b0}, // R4
    {16'd140, 5'd0,  5'd0,  5'd0,  3'd0, 3'd2, 1'b0, 1'b0}, // R4
    {16'd144, 5'd0,  5'd0,  5'd0,  3'd0, 3'd3, 1'b0, 1'b0}, // R4
    {16'd148, 5'd0,  5'd0,  5'd0,  3'd0, 3'd4, 1'b0, 1'b0}, // R4
    {16'd152, 5'd0,  5'd0,  5'd12, 3'd1, 3'd1, 1'b0, 1'b0}, // R5 row 0 full
    {16'd156, 5'd12, 5'd0,  5'd13, 3'd2, 3'd0, 1'b0, 1'b0}  // R5 dependent lifts
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Call at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input logic [31:0] pc, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] d);
    in_pc = pc; in_src_a = a; in_src_b = b; in_dst = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_place(input string req, input logic [2:0] r, input logic [2:0] c,
                              input logic nw);
    check({req, " valid"}, 64'(out_valid), 64'(1));
    check({req, " row"}, 64'(out_row), 64'(r));
    check({req, " col"}, 64'(out_col), 64'(c));
    check({req, " new_cfg"}, 64'(out_new_cfg), 64'(nw));
    check({req, " unplaceable"}, 64'(out_unplaceable), 64'(0));
  endtask

  task automatic load(input logic [24:0] m);
    defect_mask = m; defect_load = 1'b1;
    #1;
    check("R9 in_ready low during load", 64'(in_ready), 64'(0));
    @(negedge clk);
    defect_load = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", 64'(out_valid), 64'(0));
    check("R1 in_ready after reset", 64'(in_ready), 64'(1));

    for (int i = 0; i < 15; i++) begin
      logic [38:0] v;
      v = VEC[i];
      issue({16'd0, v[38:23]}, v[22:18], v[17:13], v[12:8]);
      if (v[1]) tag = {16'd0, v[38:23]};
      check($sformatf("R4 vector %0d valid", i), 64'(out_valid), 64'(1));
      check($sformatf("R4 vector %0d row", i), 64'(out_row), 64'(v[7:5]));
      check($sformatf("R4 vector %0d col", i), 64'(out_col), 64'(v[4:2]));
      check($sformatf("R7 vector %0d new_cfg", i), 64'(out_new_cfg), 64'(v[1]));
      check($sformatf("R10 vector %0d unplaceable", i), 64'(out_unplaceable), 64'(v[0]));
      check($sformatf("R8 vector %0d tag", i), 64'(out_cfg_pc), 64'(tag));
    end

    // R6 / R11: row 0 cols 0,1 and all of row 1 defective.
    load(25'h00003E3);
    issue(32'h200, 5'd0, 5'd0, 5'd0);
    expect_place("R11 reopen after load", 3'd0, 3'd2, 1'b1);
    check("R8 tag after load", 64'(out_cfg_pc), 64'h200);
    issue(32'h204, 5'd0, 5'd0, 5'd0);
    expect_place("R6 skip defect", 3'd0, 3'd3, 1'b0);
    issue(32'h208, 5'd0, 5'd0, 5'd0);
    expect_place("R6 skip defect", 3'd0, 3'd4, 1'b0);
    issue(32'h20C, 5'd0, 5'd0, 5'd20);
    expect_place("R5 over defective row", 3'd2, 3'd0, 1'b0);
    issue(32'h210, 5'd20, 5'd0, 5'd21);
    expect_place("R5 dependent above", 3'd3, 3'd0, 1'b0);
    issue(32'h214, 5'd21, 5'd0, 5'd22);
    expect_place("R3 chain", 3'd4, 3'd0, 1'b0);
    issue(32'h218, 5'd22, 5'd0, 5'd0);
    expect_place("R6 defects kept after restart R7", 3'd0, 3'd2, 1'b1);
    check("R8 tag of restart", 64'(out_cfg_pc), 64'h218);
    issue(32'h21C, 5'd0, 5'd0, 5'd0);
    expect_place("R6 fresh map", 3'd0, 3'd3, 1'b0);

    // R10: every unit defective.
    load('1);
    issue(32'h300, 5'd0, 5'd0, 5'd1);
    check("R10 unplaceable", 64'(out_unplaceable), 64'(1));
    check("R10 new_cfg", 64'(out_new_cfg), 64'(1));
    issue(32'h304, 5'd1, 5'd0, 5'd2);
    check("R10 next unplaceable", 64'(out_unplaceable), 64'(1));
    check("R10 next new_cfg", 64'(out_new_cfg), 64'(1));
    check("R8 tag unplaceable", 64'(out_cfg_pc), 64'h304);

    // R9: back-pressure on the result.
    load('0);
    out_ready = 1'b0;
    issue(32'h400, 5'd0, 5'd0, 5'd3);
    expect_place("R9 stalled result", 3'd0, 3'd0, 1'b1);
    check("R9 in_ready while pending", 64'(in_ready), 64'(0));
    in_src_a = 5'd3; in_valid = 1'b1; in_pc = 32'h404;
    repeat (2) @(negedge clk);
    check("R9 held row", 64'(out_row), 64'(0));
    check("R9 held col", 64'(out_col), 64'(0));
    check("R9 held tag", 64'(out_cfg_pc), 64'h400);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_place("R9 queued instruction after release", 3'd1, 3'd0, 1'b0);
    @(negedge clk);
    check("R9 result consumed", 64'(out_valid), 64'(0));

    finish_up();
  end

endmodule